// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block sits between a simple 32-bit word bus and a serial line engine. It buffers
characters in both directions in two 64-entry FIFOs and exposes five word registers:
a data window, an occupancy register, an interrupt status register, a control register
and a baud rate divisor. The bit timing itself belongs to the engine. The engine pushes
each received character together with a framing-error tag and a break tag. It pulls
transmit characters through a valid/ready handshake, and it signals an idle timeout
with a one-cycle pulse.

Interrupt causes are sticky. Software clears a cause by writing one to its bit in the
status register. A single registered interrupt line is the OR of the causes that the
control register enables. The receive trigger cause is the exception: it is live and
follows the receive occupancy. The transmit-request cause latches whenever the transmit
occupancy is at or below a programmable threshold, so software can refill the transmit
FIFO in bursts.

Top module: `serial_reg_front`

## Requirements
- R1: Registers sit at byte offsets 0x00 data, 0x04 level, 0x08 status, 0x0C control and 0x10 rate. A read returns its word on `bus_rdata` in the cycle after the read strobe. A read of any other offset returns zero. The control register stores and returns all 32 bits.
- R2: A read of the data offset pops one receive entry and returns it with the character in bits 7:0, the framing tag in bit 9 and the break tag in bit 10. A read while the receive FIFO is empty returns 0x100 (bit 8 set) and pops nothing.
- R3: The level register returns the transmit occupancy in bits 15:8 and the receive occupancy in bits 7:0. Neither occupancy exceeds 64.
- R4: Status bits are: 0 transmit request, 1 receive trigger, 2 receive timeout, 3 framing error, 4 break, 5 overrun, 6 transmit FIFO empty. Writing one to bit 0, 2, 3, 4 or 5 clears that cause. If a cause is set and cleared in the same cycle, the set wins.
- R5: The transmit-request cause latches in any cycle in which the transmit occupancy is at or below the threshold chosen by control bits 1:0. Codes 0, 1, 2 and 3 select 0, 4, 8 and 16.
- R6: The receive trigger bit reads one while the receive occupancy is at or above the threshold chosen by control bits 4:2. Codes 0 to 5 select 1, 4, 8, 16, 32 and 48; codes 6 and 7 select 48. A pulse on `rx_tmo` latches the timeout cause.
- R7: An arriving character tagged with a framing error latches bit 3, and one tagged as a break latches bit 4. A character that arrives while the receive FIFO holds 64 entries is dropped and latches bit 5.
- R8: `irq` is registered. It is one cycle after any cycle in which the enabled causes are active, and zero otherwise. Control bit 5 enables the transmit request. Control bit 6 enables the receive trigger and the timeout. Control bit 7 enables framing, break and overrun.
- R9: A write to the data offset pushes bits 7:0 into the transmit FIFO, and is ignored when the FIFO holds 64 entries. `tx_valid` is high while the FIFO is non-empty. `tx_char` is the oldest entry and stays stable until `tx_ready` accepts it.
- R10: Reset empties both FIFOs, clears all causes, the control register and `irq`, and loads the rate register with 0xFF. The rate register drives `rate_div`.
- R11: Status bit 6 reads one exactly when the transmit FIFO is empty. It is read-only and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rx_valid | input | 1 | Received character present this cycle |
| rx_char | input | 8 | Received character |
| rx_err | input | 1 | Framing error tag of the received character |
| rx_brk | input | 1 | Break tag of the received character |
| rx_tmo | input | 1 | Receive idle timeout pulse |
| tx_valid | output | 1 | Transmit character available |
| tx_char | output | 8 | Oldest transmit character |
| tx_ready | input | 1 | Engine accepts `tx_char` this cycle |
| rate_div | output | 8 | Baud rate divisor register |
| irq | output | 1 | Registered interrupt request |

## Verification
Two things can fall in the same cycle: a write-one-to-clear of the status register, and a new event for the same cause (a tagged character, a timeout pulse, or a transmit occupancy at threshold). A directed vector clears every sticky bit while a framing-and-break character and a timeout pulse arrive together. The bench expects those three bits to survive. The random phase also mixes status writes, pushes from both sides, data pops and engine pulls in the same cycle. A bench model predicts every read word, the occupancies and the interrupt line from the state before each edge.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 32;
  localparam int LVL_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RATE  = 5'h10;

  // index of each sticky cause inside the sticky register array
  localparam int SK_TXREQ = 0;
  localparam int SK_TMO   = 1;
  localparam int SK_FRAME = 2;
  localparam int SK_BRK   = 3;
  localparam int SK_OVR   = 4;
  localparam int SK_N     = 5;

  function automatic logic [LVL_W-1:0] rx_level_thr(input logic [2:0] code);
    case (code)
      3'd0:    return LVL_W'(1);
      3'd1:    return LVL_W'(4);
      3'd2:    return LVL_W'(8);
      3'd3:    return LVL_W'(16);
      3'd4:    return LVL_W'(32);
      default: return LVL_W'(48);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] tx_level_thr(input logic [1:0] code);
    case (code)
      2'd0:    return LVL_W'(0);
      2'd1:    return LVL_W'(4);
      2'd2:    return LVL_W'(8);
      default: return LVL_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sfe_sticky.sv
module sfe_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;   // a new event beats a clear
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import sfe_pkg::*;
#(
  parameter int          DEPTH    = 64,
  parameter logic [7:0]  RATE_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_char,
  input  logic              rx_err,
  input  logic              rx_brk,
  input  logic              rx_tmo,
  output logic              tx_valid,
  output logic [7:0]        tx_char,
  input  logic              tx_ready,
  output logic [7:0]        rate_div,
  output logic              irq
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int RX_W  = 10;

  logic sel_data, sel_level, sel_stat, sel_ctrl, sel_rate;
  assign sel_data  = (bus_addr == OFS_DATA);
  assign sel_level = (bus_addr == OFS_LEVEL);
  assign sel_stat  = (bus_addr == OFS_STAT);
  assign sel_ctrl  = (bus_addr == OFS_CTRL);
  assign sel_rate  = (bus_addr == OFS_RATE);

  // receive path: entry is {break, framing, character}
  logic [RX_W-1:0] rx_head;
  logic [CW-1:0]   rx_cnt;
  logic            rx_full, rx_empty;

  sfe_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst),
    .push(rx_valid), .din({rx_brk, rx_err, rx_char}),
    .pop(bus_rd && sel_data), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // transmit path
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_empty;

  sfe_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst),
    .push(bus_wr && sel_data), .din(bus_wdata[7:0]),
    .pop(tx_ready), .dout(tx_char),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  assign tx_valid = !tx_empty;

  // control and rate registers
  logic [WORD_W-1:0] ctrl_q;
  logic [7:0]        rate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rate_q <= RATE_RST;
    end else if (bus_wr) begin
      if (sel_ctrl) ctrl_q <= bus_wdata;
      if (sel_rate) rate_q <= bus_wdata[7:0];
    end
  end
  assign rate_div = rate_q;

  // trigger comparisons
  logic [LVL_W-1:0] rx_lvl, tx_lvl;
  logic             rx_trig, tx_low;
  assign rx_lvl  = LVL_W'(rx_cnt);
  assign tx_lvl  = LVL_W'(tx_cnt);
  assign rx_trig = (rx_lvl >= rx_level_thr(ctrl_q[4:2]));
  assign tx_low  = (tx_lvl <= tx_level_thr(ctrl_q[1:0]));

  // sticky causes
  logic [SK_N-1:0] sk_set, sk_clr, sk_q;
  always_comb begin
    sk_set           = '0;
    sk_set[SK_TXREQ] = tx_low;
    sk_set[SK_TMO]   = rx_tmo;
    sk_set[SK_FRAME] = rx_valid && rx_err;
    sk_set[SK_BRK]   = rx_valid && rx_brk;
    sk_set[SK_OVR]   = rx_valid && rx_full;
    sk_clr           = '0;
    if (bus_wr && sel_stat) begin
      sk_clr[SK_TXREQ] = bus_wdata[0];
      sk_clr[SK_TMO]   = bus_wdata[2];
      sk_clr[SK_FRAME] = bus_wdata[3];
      sk_clr[SK_BRK]   = bus_wdata[4];
      sk_clr[SK_OVR]   = bus_wdata[5];
    end
  end

  sfe_sticky #(.N(SK_N)) u_causes (
    .clk(clk), .rst(rst), .set(sk_set), .clr(sk_clr), .q(sk_q)
  );

  logic [WORD_W-1:0] stat_word, data_word, level_word;
  assign stat_word  = {25'b0, tx_empty, sk_q[SK_OVR], sk_q[SK_BRK],
                       sk_q[SK_FRAME], sk_q[SK_TMO], rx_trig, sk_q[SK_TXREQ]};
  assign data_word  = rx_empty ? 32'h0000_0100
                               : {21'b0, rx_head[9], rx_head[8], 1'b0, rx_head[7:0]};
  assign level_word = {16'b0, tx_lvl, rx_lvl};

  logic irq_d;
  assign irq_d = (ctrl_q[5] && sk_q[SK_TXREQ])
              || (ctrl_q[6] && (rx_trig || sk_q[SK_TMO]))
              || (ctrl_q[7] && (sk_q[SK_FRAME] || sk_q[SK_BRK] || sk_q[SK_OVR]));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= irq_d;
      if (bus_rd) begin
        case (1'b1)
          sel_data:  bus_rdata <= data_word;
          sel_level: bus_rdata <= level_word;
          sel_stat:  bus_rdata <= stat_word;
          sel_ctrl:  bus_rdata <= ctrl_q;
          sel_rate:  bus_rdata <= {24'b0, rate_q};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker
  import sfe_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic [CW-1:0]     rx_cnt,
  input logic [CW-1:0]     tx_cnt,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_char,
  input logic              irq,
  input logic [WORD_W-1:0] ctrl_q,
  input logic [SK_N-1:0]   sk_q,
  input logic [7:0]        rate_q
);
  assert_lvl_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

  assert_empty_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_DATA && rx_cnt == '0)
      |=> (bus_rdata[8] && bus_rdata[7:0] == 8'h00));

  assert_overrun_latch_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_cnt == CW'(DEPTH)) |=> sk_q[SK_OVR]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[7:5] == 3'b000) |=> !irq);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_char)));

  assert_rate_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rate_q == 8'hFF));
endmodule

bind serial_reg_front sfe_checker #(.DEPTH(DEPTH)) u_sfe_checker (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_cnt(rx_cnt),
  .tx_cnt(tx_cnt), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_char(tx_char), .irq(irq), .ctrl_q(ctrl_q), .sk_q(sk_q),
  .rate_q(rate_q)
);

// File: tb/serial_reg_front_tb_top.sv
module serial_reg_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_err = 1'b0, rx_brk = 1'b0, rx_tmo = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_char, rate_div;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_front #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_err(rx_err), .rx_brk(rx_brk), .rx_tmo(rx_tmo),
    .tx_valid(tx_valid), .tx_char(tx_char), .tx_ready(tx_ready),
    .rate_div(rate_div), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;

  // bench model; sticky index: 0 txreq, 1 timeout, 2 framing, 3 break, 4 overrun
  logic [9:0]  rxq[$];
  logic [7:0]  txq[$];
  logic [31:0] m_ctrl = '0;
  logic [7:0]  m_rate = 8'hFF;
  logic [4:0]  m_st = '0;
  logic        g_tr = 1'b0;

  function automatic int thr_rx(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 4;  3'd2: return 8;
      3'd3: return 16; 3'd4: return 32; default: return 48;
    endcase
  endfunction

  function automatic int thr_tx(input logic [1:0] c);
    case (c)
      2'd0: return 0; 2'd1: return 4; 2'd2: return 8; default: return 16;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00: return "R2 data read";
      5'h04: return "R3 level read";
      5'h08: return "R4 status read";
      5'h0C: return "R1 control read";
      5'h10: return "R1 rate read";
      default: return "R1 unmapped read";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus/engine cycle: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(input logic wr, input logic rd, input logic [4:0] a,
                     input logic [31:0] wd, input logic rv, input logic [7:0] rc,
                     input logic re, input logic rb, input logic rt);
    logic [31:0] e_rd;
    logic        e_irq, rxtrig;
    logic [4:0]  setv, clrv;
    int          rxn, txn;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_char = rc; rx_err = re; rx_brk = rb; rx_tmo = rt;
    tx_ready = g_tr;
    rxn = rxq.size(); txn = txq.size();
    rxtrig = (rxn >= thr_rx(m_ctrl[4:2]));
    e_irq = (m_ctrl[5] && m_st[0]) || (m_ctrl[6] && (rxtrig || m_st[1]))
         || (m_ctrl[7] && (m_st[2] || m_st[3] || m_st[4]));
    case (a)
      5'h00: e_rd = (rxn == 0) ? 32'h100
                   : {21'b0, rxq[0][9], rxq[0][8], 1'b0, rxq[0][7:0]};
      5'h04: e_rd = {16'b0, 8'(txn), 8'(rxn)};
      5'h08: e_rd = {25'b0, txn == 0, m_st[4], m_st[3], m_st[2], m_st[1], rxtrig, m_st[0]};
      5'h0C: e_rd = m_ctrl;
      5'h10: e_rd = {24'b0, m_rate};
      default: e_rd = 32'h0;
    endcase
    setv = {rv && rxn == DEPTH, rv && rb, rv && re, rt, txn <= thr_tx(m_ctrl[1:0])};
    clrv = (wr && a == 5'h08) ? {wd[5], wd[4], wd[3], wd[2], wd[0]} : 5'b0;
    @(posedge clk);
    m_st = setv | (m_st & ~clrv);
    if (rd && a == 5'h00 && rxn > 0) void'(rxq.pop_front());
    if (rv && rxn < DEPTH) rxq.push_back({rb, re, rc});
    if (g_tr && txn > 0) void'(txq.pop_front());
    if (wr && a == 5'h00 && txn < DEPTH) txq.push_back(wd[7:0]);
    if (wr && a == 5'h0C) m_ctrl = wd;
    if (wr && a == 5'h10) m_rate = wd[7:0];
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0; rx_tmo = 1'b0;
    chk("R8 irq", {31'b0, irq}, {31'b0, e_irq});
    if (rd) chk(tag_of(a), bus_rdata, e_rd);
    chk("R9 tx_valid", {31'b0, tx_valid}, {31'b0, txq.size() > 0});
    if (txq.size() > 0) chk("R9 tx_char", {24'b0, tx_char}, {24'b0, txq[0]});
    chk("R10 rate_div", {24'b0, rate_div}, {24'b0, m_rate});
  endtask

  task automatic nop();                                     cyc(0, 0, 5'h00, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d); cyc(1, 0, a, d, 0, 0, 0, 0, 0); endtask
  task automatic rd(input logic [4:0] a);                   cyc(0, 1, a, 0, 0, 0, 0, 0, 0); endtask
  task automatic rx(input logic [7:0] c, input logic e, input logic b); cyc(0, 0, 5'h00, 0, 1, c, e, b, 0); endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    chk("R10 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
    chk("R10 rate after reset", {24'b0, rate_div}, 32'hFF);
    rd(5'h04); rd(5'h0C); rd(5'h10); rd(5'h08); rd(5'h00); rd(5'h14);

    // receive trigger at 48, overrun, clear, drain
    wr(5'h0C, 32'h0000_0054);
    for (int i = 0; i < 47; i++) rx(8'(i), 1'b0, 1'b0);
    rd(5'h08); chk("R6 below threshold 48", {31'b0, bus_rdata[1]}, 32'h0);
    rx(8'd47, 1'b0, 1'b0);
    rd(5'h08); chk("R6 at threshold 48", {31'b0, bus_rdata[1]}, 32'h1);
    nop();     chk("R8 irq from rx trigger", {31'b0, irq}, 32'h1);
    for (int i = 48; i < 64; i++) rx(8'(i + 100), (i % 5) == 0, (i % 7) == 0);
    rx(8'hAA, 1'b0, 1'b0);
    rd(5'h04); chk("R7 full rx drops char", {24'b0, bus_rdata[7:0]}, 32'd64);
    rd(5'h08); chk("R7 overrun latched", {31'b0, bus_rdata[5]}, 32'h1);
    wr(5'h08, 32'h20);
    rd(5'h08); chk("R4 overrun cleared by w1c", {31'b0, bus_rdata[5]}, 32'h0);
    for (int i = 0; i < 64; i++) rd(5'h00);
    rd(5'h00); chk("R2 empty read word", bus_rdata, 32'h100);
    rd(5'h04); chk("R2 empty read pops nothing", {24'b0, bus_rdata[7:0]}, 32'h0);

    // transmit fill, ignore when full, threshold latch
    g_tr = 1'b0;
    wr(5'h0C, 32'h0000_0022);
    for (int i = 0; i < 65; i++) wr(5'h00, 32'(i + 1));
    rd(5'h04); chk("R9 write to full tx ignored", {24'b0, bus_rdata[15:8]}, 32'd64);
    wr(5'h08, 32'h1);
    rd(5'h08); chk("R5 no request above threshold", {31'b0, bus_rdata[0]}, 32'h0);
    g_tr = 1'b1;
    repeat (56) nop();
    g_tr = 1'b0;
    rd(5'h04); chk("R9 tx level after drain", {24'b0, bus_rdata[15:8]}, 32'd8);
    rd(5'h08); chk("R5 request at threshold 8", {31'b0, bus_rdata[0]}, 32'h1);
    nop();     chk("R8 irq from tx request", {31'b0, irq}, 32'h1);
    g_tr = 1'b1;
    repeat (8) nop();
    g_tr = 1'b0;
    rd(5'h08); chk("R11 tx empty flag", {31'b0, bus_rdata[6]}, 32'h1);

    // w1c of all causes while framing, break and timeout events arrive
    cyc(1, 0, 5'h08, 32'h3D, 1, 8'h11, 1, 1, 1);
    rd(5'h08); chk("R4 set wins over clear", {29'b0, bus_rdata[4:2]}, 32'h7);
    rd(5'h00); chk("R7 tagged char read", bus_rdata, 32'h611);
    wr(5'h08, 32'h3D);
    rd(5'h08); chk("R6 timeout cleared", {31'b0, bus_rdata[2]}, 32'h0);
    wr(5'h0C, 32'h0);
    rx(8'h5A, 1'b1, 1'b0);
    nop();     chk("R8 masked causes", {31'b0, irq}, 32'h0);
    rd(5'h00);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic        w, r, v, e, b, t;
      logic [4:0]  wa, ra;
      logic [31:0] wd;
      int          p;
      p  = $urandom_range(0, 4);
      wa = (p < 2) ? 5'h00 : (p == 2) ? 5'h08 : (p == 3) ? 5'h0C : 5'h10;
      p  = $urandom_range(0, 6);
      ra = (p < 2) ? 5'h00 : (p == 2) ? 5'h04 : (p == 3) ? 5'h08
         : (p == 4) ? 5'h0C : (p == 5) ? 5'h10 : 5'h14;
      w  = ($urandom_range(0, 99) < 20);
      r  = ($urandom_range(0, 99) < 30);
      v  = ($urandom_range(0, 99) < 45);
      e  = ($urandom_range(0, 9) == 0);
      b  = ($urandom_range(0, 14) == 0);
      t  = ($urandom_range(0, 29) == 0);
      wd = $urandom();
      g_tr = ($urandom_range(0, 2) == 0);
      cyc(w, r, r ? ra : wa, wd, v, 8'($urandom()), e, b, t);
      if (r && w) begin end
    end

    summary();
    $finish;
  end
endmodule